// File: doc/BRIEF.md
# Byte-Serial Vector Memory Loader

This block fills a wide vector memory from a host that has only a byte-wide data path. Each stored vector spans eleven byte-wide memory lanes: ten pattern lanes, which together carry the forty output channels and their companion bits, and one control lane that holds the per-vector control byte. The host writes the pattern bytes and then the control byte to a single data port, one byte per write. An internal lane counter picks the lane for each byte and moves on by one after every port write. After the control lane has been written, the counter returns to the first pattern lane and the vector address moves on by one. Loading a full pattern is therefore a stream of port writes.

The host side is a two-bit register offset, a data byte and a write strobe. A write takes effect on the rising edge of the strobe, seen synchronously in the block's clock domain. Two further offsets set the low and high parts of the vector address, and either of them also sends the lane counter back to the first pattern lane. The memory side is a shared address, a shared data byte and one write enable per lane, all registered. Each enable pulses for one clock.

Top module: `vml_loader`

## Requirements
- R1: After synchronous reset no lane enable is asserted, the memory address is 0, and the first data-port write goes to lane 0 (first pattern lane) at vector 0.
- R2: A rising edge of `host_wr` with `host_addr` = 0 (data port) asserts exactly one bit of `lane_we` for exactly the next clock. During that clock `mem_wdata` carries the byte and `mem_addr` carries the vector address that was current at the write.
- R3: Successive data-port writes select lanes 0 to 9 (pattern) in order and then lane 10 (control). Inside the block these are lane counter values 5 to 15.
- R4: The data-port write that goes to lane 10 advances the vector address by one, and the next data-port write goes to lane 0.
- R5: A write to offset 1 sets vector address bits [7:0] from the data byte. A write to offset 2 sets the remaining upper address bits from the low bits of the data byte and ignores the other data bits. Either write makes the next data-port write go to lane 0. Neither write asserts any lane enable.
- R6: The vector address wraps from its all-ones value to 0 when the control lane is written.
- R7: Holding `host_wr` high for several clocks performs a single write. A further write needs a new rising edge.
- R8: A write to offset 3 asserts no lane enable and leaves the lane selection and the vector address unchanged.
- R9: At most one bit of `lane_we` is high in any clock. No bit is high in a clock that does not follow a data-port write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 2 | Register offset: 0 data port, 1 address low, 2 address high, 3 unused |
| host_wdata | input | DATA_W | Host write byte |
| host_wr | input | 1 | Write strobe; acts on its rising edge |
| mem_addr | output | VEC_AW | Shared vector address for all lanes |
| mem_wdata | output | DATA_W | Shared write byte for all lanes |
| lane_we | output | PAT_LANES+1 | One write enable per lane; the top bit is the control lane |

## Verification
The bench builds the loader with a 9-bit vector address (512 vectors) and keeps the other parameters at their defaults. With that setting the high-address register is a single bit, so the test can confirm that the other bits of a high-offset byte are discarded. The same setting brings the wrap from vector 511 back to 0 within a couple of dozen writes. The bench's lane memories are indexed by the low four address bits. Reading them back shows that the control byte landed in the control lane at the intended vector.

// File: rtl/vml_pkg.sv
package vml_pkg;

    localparam int REG_AW = 2;

    typedef enum logic [REG_AW-1:0] {
        SEL_PORT  = 2'd0,
        SEL_VLO   = 2'd1,
        SEL_VHI   = 2'd2,
        SEL_SPARE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic port;
        logic set_lo;
        logic set_hi;
    } host_op_t;

    function automatic host_op_t decode_op(input logic evt, input logic [REG_AW-1:0] a);
        host_op_t op;
        op = '0;
        if (evt) begin
            case (reg_sel_e'(a))
                SEL_PORT: op.port   = 1'b1;
                SEL_VLO:  op.set_lo = 1'b1;
                SEL_VHI:  op.set_hi = 1'b1;
                default:  op        = '0;
            endcase
        end
        return op;
    endfunction

endpackage

// File: rtl/vml_strobe_edge.sv
module vml_strobe_edge (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    output logic rise
);
    logic strobe_q;

    always_ff @(posedge clk) begin
        if (rst) strobe_q <= 1'b0;
        else     strobe_q <= strobe;
    end

    assign rise = strobe & ~strobe_q;

    // R7: an edge can never be seen on two consecutive clocks
    a_r7_single_edge: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);
endmodule

// File: rtl/vml_lane_seq.sv
module vml_lane_seq
    import vml_pkg::*;
#(
    parameter int VEC_AW   = 13,
    parameter int DATA_W   = 8,
    parameter int CNT_W    = 4,
    parameter int CNT_BASE = 5,
    parameter int LANES    = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  host_op_t          op,
    input  logic [DATA_W-1:0] data,
    output logic [CNT_W-1:0]  cnt,
    output logic [VEC_AW-1:0] vaddr
);
    localparam int HI_W = VEC_AW - DATA_W;
    localparam logic [CNT_W-1:0] C_BASE = CNT_W'(CNT_BASE);
    localparam logic [CNT_W-1:0] C_LAST = CNT_W'(CNT_BASE + LANES - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= C_BASE;
            vaddr <= '0;
        end else if (op.set_lo) begin
            vaddr[DATA_W-1:0] <= data;
            cnt               <= C_BASE;
        end else if (op.set_hi) begin
            vaddr[VEC_AW-1:DATA_W] <= data[HI_W-1:0];
            cnt                    <= C_BASE;
        end else if (op.port) begin
            if (cnt == C_LAST) begin
                cnt   <= C_BASE;
                vaddr <= vaddr + VEC_AW'(1);
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    a_r3_step: assert property (@(posedge clk) disable iff (rst)
        (op.port && cnt != C_LAST) |=> (cnt == $past(cnt) + CNT_W'(1)) && $stable(vaddr));

    a_r4_next_vector: assert property (@(posedge clk) disable iff (rst)
        (op.port && cnt == C_LAST) |=> (cnt == C_BASE) && (vaddr == $past(vaddr) + VEC_AW'(1)));

    a_r5_restart: assert property (@(posedge clk) disable iff (rst)
        (op.set_lo || op.set_hi) |=> (cnt == C_BASE));

    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !(op.port || op.set_lo || op.set_hi) |=> $stable(cnt) && $stable(vaddr));

    a_r3_range: assert property (@(posedge clk) disable iff (rst)
        (cnt >= C_BASE) && (cnt <= C_LAST));
endmodule

// File: rtl/vml_lane_dec.sv
module vml_lane_dec #(
    parameter int CNT_W    = 4,
    parameter int CNT_BASE = 5,
    parameter int LANES    = 11
) (
    input  logic             port_wr,
    input  logic [CNT_W-1:0] cnt,
    output logic [LANES-1:0] we
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [CNT_W-1:0] SEL = CNT_W'(CNT_BASE + i);
        assign we[i] = port_wr && (cnt == SEL);
    end
endmodule

// File: rtl/vml_loader.sv
module vml_loader
    import vml_pkg::*;
#(
    parameter int PAT_LANES = 10,
    parameter int VEC_AW    = 13,
    parameter int DATA_W    = 8,
    parameter int CNT_W     = 4,
    parameter int CNT_BASE  = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           host_addr,
    input  logic [DATA_W-1:0]    host_wdata,
    input  logic                 host_wr,
    output logic [VEC_AW-1:0]    mem_addr,
    output logic [DATA_W-1:0]    mem_wdata,
    output logic [PAT_LANES:0]   lane_we
);
    localparam int LANES = PAT_LANES + 1;

    logic              rise;
    host_op_t          op;
    logic [CNT_W-1:0]  cnt;
    logic [VEC_AW-1:0] vaddr;
    logic [LANES-1:0]  we_next;

    vml_strobe_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .strobe (host_wr),
        .rise   (rise)
    );

    assign op = decode_op(rise, host_addr);

    vml_lane_seq #(
        .VEC_AW   (VEC_AW),
        .DATA_W   (DATA_W),
        .CNT_W    (CNT_W),
        .CNT_BASE (CNT_BASE),
        .LANES    (LANES)
    ) u_seq (
        .clk   (clk),
        .rst   (rst),
        .op    (op),
        .data  (host_wdata),
        .cnt   (cnt),
        .vaddr (vaddr)
    );

    vml_lane_dec #(
        .CNT_W    (CNT_W),
        .CNT_BASE (CNT_BASE),
        .LANES    (LANES)
    ) u_dec (
        .port_wr (op.port),
        .cnt     (cnt),
        .we      (we_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lane_we   <= '0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            lane_we <= we_next;
            if (op.port) begin
                mem_addr  <= vaddr;
                mem_wdata <= host_wdata;
            end
        end
    end

    a_r9_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lane_we));

    a_r2_one_clock: assert property (@(posedge clk) disable iff (rst)
        (|lane_we) |=> (lane_we == '0));

    a_r2_payload: assert property (@(posedge clk) disable iff (rst)
        (|lane_we) |-> (mem_addr == $past(vaddr)) && (mem_wdata == $past(host_wdata)));

    a_r9_needs_port: assert property (@(posedge clk) disable iff (rst)
        !(rise && host_addr == 2'd0) |=> (lane_we == '0));
endmodule

// File: tb/vml_loader_tb.sv
module vml_loader_tb;
    localparam int VA = 9;
    localparam int NL = 11;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    host_addr = '0;
    logic [7:0]    host_wdata = '0;
    logic          host_wr = 1'b0;
    logic [VA-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic [NL-1:0] lane_we;

    int errors = 0;
    int checks = 0;
    int multi_hot = 0;

    always #10 clk = ~clk;

    vml_loader #(.VEC_AW(VA)) u_dut (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_wr(host_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .lane_we(lane_we)
    );

    logic [7:0] bmem [NL][16];
    always @(posedge clk) begin
        for (int i = 0; i < NL; i++)
            if (lane_we[i]) bmem[i][mem_addr[3:0]] <= mem_wdata;
        if (!rst && $countones(lane_we) > 1) multi_hot++;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    logic [NL-1:0] s_we, s_we_after;
    logic [VA-1:0] s_ad;
    logic [7:0]    s_wd;

    task automatic wr_cycle(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        s_we = lane_we; s_ad = mem_addr; s_wd = mem_wdata;
        host_wr = 1'b0;
        @(negedge clk);
        s_we_after = lane_we;
    endtask

    int exp_lane = 0;
    int exp_va = 0;

    task automatic port_write(input logic [7:0] d, input string tag);
        wr_cycle(2'd0, d);
        chk(s_we == (NL'(1) << exp_lane), {tag, " lane"}, int'(s_we), int'(NL'(1) << exp_lane));
        chk(int'(s_ad) == exp_va, {tag, " addr"}, int'(s_ad), exp_va);
        chk(s_wd == d && s_we_after == '0, {tag, " data/pulse R2"}, int'(s_wd), int'(d));
        exp_lane++;
        if (exp_lane == NL) begin
            exp_lane = 0;
            exp_va = (exp_va + 1) % (1 << VA);
        end
    endtask

    task automatic set_addr(input int va);
        wr_cycle(2'd1, 8'(va));
        wr_cycle(2'd2, 8'(va >> 8) | 8'hFE);
        exp_va = va; exp_lane = 0;
    endtask

    // {offset, data, expected lane_we, expected mem_addr}
    localparam logic [29:0] TBL [8] = '{
        {2'd0, 8'h11, 11'h001, 9'd0},
        {2'd0, 8'h22, 11'h002, 9'd0},
        {2'd1, 8'h07, 11'h000, 9'd0},
        {2'd0, 8'h33, 11'h001, 9'd7},
        {2'd2, 8'hFD, 11'h000, 9'd0},
        {2'd0, 8'h44, 11'h001, 9'd263},
        {2'd3, 8'h55, 11'h000, 9'd0},
        {2'd0, 8'h66, 11'h002, 9'd263}
    };

    initial begin
        #4_000_000;
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(lane_we == '0, "R1 lane_we after reset", int'(lane_we), 0);
        chk(mem_addr == '0, "R1 mem_addr after reset", int'(mem_addr), 0);

        // table walk: R1 R2 R3 R5 R8
        for (int i = 0; i < 8; i++) begin
            wr_cycle(TBL[i][29:28], TBL[i][27:20]);
            chk(s_we == TBL[i][19:9], $sformatf("R2/R5/R8 table %0d lane_we", i),
                int'(s_we), int'(TBL[i][19:9]));
            if (TBL[i][19:9] != '0) begin
                chk(s_ad == TBL[i][8:0], $sformatf("R5 table %0d addr", i),
                    int'(s_ad), int'(TBL[i][8:0]));
                chk(s_wd == TBL[i][27:20], $sformatf("R2 table %0d data", i),
                    int'(s_wd), int'(TBL[i][27:20]));
            end
        end

        // R3 R4: full vector at 16, then next vector
        set_addr(16);
        for (int k = 0; k < NL; k++) port_write(8'(8'hA0 + k), $sformatf("R3 byte %0d", k));
        port_write(8'hB0, "R4 next vector");
        chk(bmem[10][0] == 8'hAA, "R4 control lane memory", int'(bmem[10][0]), 'hAA);
        chk(bmem[0][1] == 8'hB0, "R4 lane0 next vector memory", int'(bmem[0][1]), 'hB0);

        // R8: spare offset leaves state alone
        wr_cycle(2'd3, 8'h5A);
        chk(s_we == '0, "R8 spare lane_we", int'(s_we), 0);
        port_write(8'hB1, "R8 after spare");

        // R7: strobe held high
        begin
            int pulses = 0;
            @(negedge clk);
            host_addr = 2'd0; host_wdata = 8'hC7; host_wr = 1'b1;
            repeat (5) begin
                @(negedge clk);
                if (lane_we != '0) pulses++;
            end
            host_wr = 1'b0;
            @(negedge clk);
            chk(pulses == 1, "R7 held strobe pulses", pulses, 1);
            exp_lane++;
            port_write(8'hC8, "R7 following write");
        end

        // R6: wrap at top address
        set_addr((1 << VA) - 1);
        for (int k = 0; k < NL; k++) port_write(8'(k), "R6 last vector");
        port_write(8'hEE, "R6 wrapped to 0");

        // R1: reset mid-vector
        port_write(8'h01, "R1 pre-reset");
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        exp_lane = 0; exp_va = 0;
        port_write(8'h9C, "R1 after mid reset");

        chk(multi_hot == 0, "R9 multi-hot clocks", multi_hot, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule